// File: doc/BRIEF.md
# Vectored Interrupt Request Unit

This unit sits beside a processor core and turns interrupt requests into a service-routine start address. It watches four hardware request lines and one software restart request. The hardware lines are a trap line that no mask can block and three maskable restart levels, named 7.5, 6.5 and 5.5. The software request carries a 3-bit restart number. The unit chooses one request by fixed priority and holds that request's 16-bit vector on its output until the core acknowledges it.

Each maskable level has its own mask bit, and all three also depend on one global enable. The global enable drops by itself whenever a maskable request is accepted, and software turns it back on with a one-cycle set pulse. Level 7.5 latches a rising edge and keeps it pending until it is acknowledged or cleared by command. Levels 6.5 and 5.5 follow their inputs. The trap needs a rising edge and the line must then stay high until the trap is taken. Software restart n vectors to n times 8. The hardware vectors run from 0024h in steps of 8: the trap at 0024h, then level 5.5, then 6.5, then 7.5.

Top module: `vec_irq_unit`

## Requirements
- R1: On a synchronous active-high `rst`, the unit clears every pending latch, sets all three mask bits, clears the global enable, and drives `vector_valid`, `vector_addr` and `grant_src` to 0.
- R2: A trap request is presented whatever the mask bits and the global enable hold, and it does not change the global enable.
- R3: Hardware vectors are 0024h for the trap, 002Ch for level 5.5, 0034h for level 6.5 and 003Ch for level 7.5. `grant_src` codes are 1 for trap, 2 for 7.5, 3 for 6.5, 4 for 5.5, 5 for software, and 0 when idle.
- R4: A software request with index n vectors to n*8 (0000h to 0038h) and is reported as `grant_src` 5.
- R5: When more than one request is eligible in the same cycle, the unit takes them in this order: trap, then 7.5, then 6.5, then 5.5, then software. Software is taken only when no hardware request is eligible.
- R6: `mask_wr` loads `mask_wdata` into the mask register on the next edge. Bit 0 masks 5.5, bit 1 masks 6.5 and bit 2 masks 7.5, and a 1 blocks the level.
- R7: A maskable level is eligible only while the global enable is 1. Accepting 7.5, 6.5 or 5.5 clears the enable, and this clear wins over an `ie_set` in the same cycle. An `ie_set` pulse sets the enable otherwise. `ie_state` shows the enable.
- R8: Level 7.5 latches a rising edge even while masked. The latch clears when 7.5 is acknowledged or when `rst75_cmd` is pulsed, and a clear wins over an edge in the same cycle.
- R9: The trap latches a rising edge. The latch is dropped if the line goes low before the trap is taken, and it is cleared when the trap is acknowledged. A trap line that stays high does not raise a second request.
- R10: Once `vector_valid` rises, it stays high, with `vector_addr` and `grant_src` unchanged, until `ack`. After `ack` the unit is idle for one cycle. An `ack` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap request line |
| lvl75_in | input | 1 | Level 7.5 request, edge latched |
| lvl65_in | input | 1 | Level 6.5 request, level sensitive |
| lvl55_in | input | 1 | Level 5.5 request, level sensitive |
| sw_req_valid | input | 1 | Software restart request held by requester |
| sw_req_idx | input | 3 | Software restart number |
| mask_wr | input | 1 | Load mask register |
| mask_wdata | input | 3 | New mask bits {7.5, 6.5, 5.5} |
| ie_set | input | 1 | Pulse that sets the global enable |
| rst75_cmd | input | 1 | Pulse that clears the 7.5 latch |
| ack | input | 1 | Acknowledge of the presented vector |
| vector_valid | output | 1 | A vector is presented |
| vector_addr | output | 16 | Service routine address |
| grant_src | output | 3 | Source code of the presented request |
| ie_state | output | 1 | Current global enable |

## Verification
The bench drives a short trap pulse that drops before it can be taken. A design that takes edges alone would present 0024h, which it must not do. A 7.5 edge is latched while masked and then cleared by command. A design that gates the latch with the mask, or that lets the clear lose, would show a late 003Ch. Level 6.5 is held high across an acknowledge. It must not be presented again until `ie_set`; a design missing the automatic enable clear would present it again at once. All lines, including software, are raised together and then drained. A wrong priority order or a software request that pushes ahead of hardware shows up as a wrong source code.

// File: rtl/vec_irq_pkg.sv
`timescale 1ns/1ps
package vec_irq_pkg;

   // Source codes reported on grant_src; hardware codes are priority index + 1
   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_TRAP = 3'd1,
      SRC_L75  = 3'd2,
      SRC_L65  = 3'd3,
      SRC_L55  = 3'd4,
      SRC_SW   = 3'd5
   } irq_src_e;

   localparam int HW_LINES  = 4;   // trap, 7.5, 6.5, 5.5 in priority order
   localparam int MASK_BITS = 3;   // one per maskable level

   function automatic logic is_maskable(input logic [2:0] src);
      return (src == SRC_L75) || (src == SRC_L65) || (src == SRC_L55);
   endfunction

endpackage

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
// Rising-edge request latch; HOLD_LEVEL variant also demands the line stays high
module irq_edge_latch #(
   parameter bit HOLD_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   input  logic clr,
   output logic armed
);

   logic prev_q;
   logic pend_q;
   logic pend_next;
   logic rise;

   assign rise = line_in & ~prev_q;

   generate
      if (HOLD_LEVEL) begin : g_hold
         // pending survives only while the line stays asserted
         assign pend_next = (pend_q | rise) & ~clr & line_in;
         assign armed     = pend_q & line_in;
      end else begin : g_edge
         assign pend_next = (pend_q | rise) & ~clr;
         assign armed     = pend_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= line_in;
         pend_q <= pend_next;
      end
   end

endmodule

// File: rtl/irq_gate_ctrl.sv
`timescale 1ns/1ps
// Mask register and global enable
module irq_gate_ctrl #(
   parameter int N_MASK = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mask_wr,
   input  logic [N_MASK-1:0] mask_wdata,
   input  logic              ie_set,
   input  logic              accept_maskable,
   output logic [N_MASK-1:0] mask_q,
   output logic              ie_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= {N_MASK{1'b1}};
      end else if (mask_wr) begin
         mask_q <= mask_wdata;
      end
   end

   // acceptance of a maskable level wins over a set pulse
   always_ff @(posedge clk) begin
      if (rst) begin
         ie_q <= 1'b0;
      end else if (accept_maskable) begin
         ie_q <= 1'b0;
      end else if (ie_set) begin
         ie_q <= 1'b1;
      end
   end

endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
// Fixed priority pick and vector generation
module irq_prio_sel
   import vec_irq_pkg::*;
#(
   parameter int VEC_W    = 16,
   parameter int SW_N     = 8,
   parameter int HW_BASE  = 'h24,
   parameter int STEP     = 8,
   localparam int SW_IDX_W = $clog2(SW_N)
) (
   input  logic                 trap_arm,
   input  logic                 l75_arm,
   input  logic                 l65_lvl,
   input  logic                 l55_lvl,
   input  logic [MASK_BITS-1:0] mask,
   input  logic                 ie,
   input  logic                 sw_valid,
   input  logic [SW_IDX_W-1:0]  sw_idx,
   output logic                 any_req,
   output logic [2:0]           sel_src,
   output logic [VEC_W-1:0]     sel_vec
);

   logic [HW_LINES-1:0] hw_req;
   logic [VEC_W-1:0]    hw_vec [HW_LINES];
   logic [VEC_W-1:0]    sw_vec;

   // index 0 has the highest priority
   assign hw_req[0] = trap_arm;
   assign hw_req[1] = l75_arm & ~mask[2] & ie;
   assign hw_req[2] = l65_lvl & ~mask[1] & ie;
   assign hw_req[3] = l55_lvl & ~mask[0] & ie;

   // address slot: trap 0, then 5.5, 6.5, 7.5 ascending
   generate
      for (genvar i = 0; i < HW_LINES; i++) begin : g_hwvec
         localparam int SLOT = (i == 0) ? 0 : (HW_LINES - i);
         assign hw_vec[i] = VEC_W'(HW_BASE + STEP * SLOT);
      end
   endgenerate

   assign sw_vec = VEC_W'(sw_idx) * VEC_W'(STEP);

   always_comb begin
      sel_src = SRC_NONE;
      sel_vec = '0;
      if (sw_valid) begin
         sel_src = SRC_SW;
         sel_vec = sw_vec;
      end
      // walk from lowest to highest so the highest eligible line is kept
      for (int i = HW_LINES - 1; i >= 0; i--) begin
         if (hw_req[i]) begin
            sel_src = 3'(i + 1);
            sel_vec = hw_vec[i];
         end
      end
   end

   assign any_req = (|hw_req) | sw_valid;

endmodule

// File: rtl/irq_vec_hold.sv
`timescale 1ns/1ps
// Output register holding one vector until acknowledged
module irq_vec_hold #(
   parameter int VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [2:0]       sel_src,
   input  logic [VEC_W-1:0] sel_vec,
   input  logic             ack,
   output logic             valid_q,
   output logic [VEC_W-1:0] addr_q,
   output logic [2:0]       src_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         src_q   <= '0;
      end else if (valid_q && ack) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         src_q   <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         addr_q  <= sel_vec;
         src_q   <= sel_src;
      end
   end

endmodule

// File: rtl/vec_irq_unit.sv
`timescale 1ns/1ps
module vec_irq_unit
   import vec_irq_pkg::*;
#(
   parameter int VEC_W    = 16,
   parameter int SW_N     = 8,
   parameter int HW_BASE  = 'h24,
   parameter int STEP     = 8,
   localparam int SW_IDX_W = $clog2(SW_N)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 trap_in,
   input  logic                 lvl75_in,
   input  logic                 lvl65_in,
   input  logic                 lvl55_in,
   input  logic                 sw_req_valid,
   input  logic [SW_IDX_W-1:0]  sw_req_idx,
   input  logic                 mask_wr,
   input  logic [MASK_BITS-1:0] mask_wdata,
   input  logic                 ie_set,
   input  logic                 rst75_cmd,
   input  logic                 ack,
   output logic                 vector_valid,
   output logic [VEC_W-1:0]     vector_addr,
   output logic [2:0]           grant_src,
   output logic                 ie_state
);

   // elaboration checks
   if (VEC_W < 8) begin : g_bad_width
      $error("vec_irq_unit: VEC_W must be at least 8");
   end
   if (SW_N < 2 || (SW_N & (SW_N - 1)) != 0) begin : g_bad_swn
      $error("vec_irq_unit: SW_N must be a power of two, at least 2");
   end
   if (HW_BASE + STEP * (HW_LINES - 1) >= (1 << VEC_W)) begin : g_bad_base
      $error("vec_irq_unit: hardware vectors exceed VEC_W");
   end

   logic                 trap_arm;
   logic                 l75_arm;
   logic                 trap_clr;
   logic                 l75_clr;
   logic                 acked;
   logic                 any_req;
   logic                 load;
   logic                 accept_maskable;
   logic [2:0]           sel_src;
   logic [VEC_W-1:0]     sel_vec;
   logic [MASK_BITS-1:0] mask_q;

   assign acked    = vector_valid & ack;
   assign trap_clr = acked & (grant_src == SRC_TRAP);
   assign l75_clr  = (acked & (grant_src == SRC_L75)) | rst75_cmd;
   assign load     = ~vector_valid & any_req;
   assign accept_maskable = load & is_maskable(sel_src);

   irq_edge_latch #(.HOLD_LEVEL(1'b1)) i_trap_latch (
      .clk     (clk),
      .rst     (rst),
      .line_in (trap_in),
      .clr     (trap_clr),
      .armed   (trap_arm)
   );

   irq_edge_latch #(.HOLD_LEVEL(1'b0)) i_l75_latch (
      .clk     (clk),
      .rst     (rst),
      .line_in (lvl75_in),
      .clr     (l75_clr),
      .armed   (l75_arm)
   );

   irq_gate_ctrl #(.N_MASK(MASK_BITS)) i_gate (
      .clk             (clk),
      .rst             (rst),
      .mask_wr         (mask_wr),
      .mask_wdata      (mask_wdata),
      .ie_set          (ie_set),
      .accept_maskable (accept_maskable),
      .mask_q          (mask_q),
      .ie_q            (ie_state)
   );

   irq_prio_sel #(
      .VEC_W   (VEC_W),
      .SW_N    (SW_N),
      .HW_BASE (HW_BASE),
      .STEP    (STEP)
   ) i_sel (
      .trap_arm (trap_arm),
      .l75_arm  (l75_arm),
      .l65_lvl  (lvl65_in),
      .l55_lvl  (lvl55_in),
      .mask     (mask_q),
      .ie       (ie_state),
      .sw_valid (sw_req_valid),
      .sw_idx   (sw_req_idx),
      .any_req  (any_req),
      .sel_src  (sel_src),
      .sel_vec  (sel_vec)
   );

   irq_vec_hold #(.VEC_W(VEC_W)) i_hold (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .sel_src (sel_src),
      .sel_vec (sel_vec),
      .ack     (ack),
      .valid_q (vector_valid),
      .addr_q  (vector_addr),
      .src_q   (grant_src)
   );

endmodule

// File: rtl/vec_irq_unit_chk.sv
`timescale 1ns/1ps
module vec_irq_unit_chk #(
   parameter int VEC_W   = 16,
   parameter int SW_N    = 8,
   parameter int HW_BASE = 'h24,
   parameter int STEP    = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             ack,
   input logic             vector_valid,
   input logic [VEC_W-1:0] vector_addr,
   input logic [2:0]       grant_src,
   input logic             ie_state
);

   logic maskable_src;
   logic [VEC_W-1:0] hw_expect;

   assign maskable_src = (grant_src >= 3'd2) && (grant_src <= 3'd4);
   assign hw_expect = (grant_src == 3'd1) ? VEC_W'(HW_BASE)            :
                      (grant_src == 3'd4) ? VEC_W'(HW_BASE + STEP)     :
                      (grant_src == 3'd3) ? VEC_W'(HW_BASE + 2 * STEP) :
                                            VEC_W'(HW_BASE + 3 * STEP);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !vector_valid && !ie_state);                            // R1

   AST_HW_VECTOR: assert property (@(posedge clk) disable iff (rst)
      vector_valid && grant_src >= 3'd1 && grant_src <= 3'd4
      |-> vector_addr == hw_expect);                                         // R3

   AST_SW_VECTOR: assert property (@(posedge clk) disable iff (rst)
      vector_valid && grant_src == 3'd5
      |-> (vector_addr % VEC_W'(STEP)) == '0 && vector_addr < VEC_W'(SW_N * STEP)); // R4

   AST_ENABLE_NEEDED: assert property (@(posedge clk) disable iff (rst)
      $rose(vector_valid) && maskable_src |-> $past(ie_state));              // R7

   AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
      $rose(vector_valid) && maskable_src |-> !ie_state);                    // R7

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      vector_valid && !ack |=> vector_valid && $stable(vector_addr) && $stable(grant_src)); // R10

   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
      vector_valid && ack |=> !vector_valid);                                // R10

   AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
      !vector_valid |-> grant_src == 3'd0 && vector_addr == '0);             // R10

endmodule

bind vec_irq_unit vec_irq_unit_chk #(
   .VEC_W   (VEC_W),
   .SW_N    (SW_N),
   .HW_BASE (HW_BASE),
   .STEP    (STEP)
) i_chk (.*);

// File: tb/test_vec_irq_unit.sv
`timescale 1ns/1ps
module test_vec_irq_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        trap_in = 0, lvl75_in = 0, lvl65_in = 0, lvl55_in = 0;
   logic        sw_req_valid = 0;
   logic [2:0]  sw_req_idx = 0;
   logic        mask_wr = 0;
   logic [2:0]  mask_wdata = 0;
   logic        ie_set = 0, rst75_cmd = 0, ack = 0;
   logic        vector_valid;
   logic [15:0] vector_addr;
   logic [2:0]  grant_src;
   logic        ie_state;

   int n_vec = 0;
   int n_bad = 0;
   bit run_cmp = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;   // 125 MHz

   vec_irq_unit i_vec_irq_unit (
      .clk(clk), .rst(rst), .trap_in(trap_in), .lvl75_in(lvl75_in),
      .lvl65_in(lvl65_in), .lvl55_in(lvl55_in), .sw_req_valid(sw_req_valid),
      .sw_req_idx(sw_req_idx), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .ie_set(ie_set), .rst75_cmd(rst75_cmd), .ack(ack),
      .vector_valid(vector_valid), .vector_addr(vector_addr),
      .grant_src(grant_src), .ie_state(ie_state)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_valid, m_addr, m_src, m_ie, m_mask, m_tp, m_tprev, m_rp, m_rprev;
   int w_src, acked, n_tp, n_rp;

   function automatic int src_addr(int src, int idx);
      case (src)
         1: return 'h24;
         2: return 'h3C;
         3: return 'h34;
         4: return 'h2C;
         5: return idx * 8;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_valid = 0; m_addr = 0; m_src = 0; m_ie = 0; m_mask = 7;
         m_tp = 0; m_tprev = 0; m_rp = 0; m_rprev = 0;
      end else begin
         w_src = 0;
         if (m_valid == 0) begin
            if (m_tp != 0 && trap_in) w_src = 1;
            else if (m_rp != 0 && m_ie != 0 && m_mask[2] == 0) w_src = 2;
            else if (lvl65_in && m_ie != 0 && m_mask[1] == 0) w_src = 3;
            else if (lvl55_in && m_ie != 0 && m_mask[0] == 0) w_src = 4;
            else if (sw_req_valid) w_src = 5;
         end
         acked = (m_valid != 0 && ack) ? 1 : 0;
         n_tp = (trap_in && (m_tp != 0 || m_tprev == 0) && !(acked != 0 && m_src == 1)) ? 1 : 0;
         n_rp = ((m_rp != 0 || (lvl75_in && m_rprev == 0)) && !(acked != 0 && m_src == 2)
                 && !rst75_cmd) ? 1 : 0;
         if (w_src >= 2 && w_src <= 4) m_ie = 0;
         else if (ie_set) m_ie = 1;
         if (acked != 0) begin
            m_valid = 0; m_addr = 0; m_src = 0;
         end else if (w_src != 0) begin
            m_valid = 1; m_src = w_src; m_addr = src_addr(w_src, int'(sw_req_idx));
         end
         if (mask_wr) m_mask = int'(mask_wdata);
         m_tp = n_tp; m_rp = n_rp;
         m_tprev = trap_in ? 1 : 0;
         m_rprev = lvl75_in ? 1 : 0;
      end
   end

   always @(negedge clk) begin
      if (run_cmp) begin
         chk(cur_req, "model valid", int'(vector_valid), m_valid);
         chk(cur_req, "model addr",  int'(vector_addr),  m_addr);
         chk(cur_req, "model src",   int'(grant_src),    m_src);
         chk(cur_req, "model ie",    int'(ie_state),     m_ie);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic expect_vec(string req, int src, int addr);
      for (int i = 0; i < 6; i++) begin
         if (vector_valid) begin
            chk(req, "source", int'(grant_src), src);
            chk(req, "vector", int'(vector_addr), addr);
            return;
         end
         tick();
      end
      chk(req, "vector_valid (timeout)", 0, 1);
   endtask

   task automatic expect_idle(string req, int cycles);
      for (int i = 0; i < cycles; i++) begin
         chk(req, "idle vector_valid", int'(vector_valid), 0);
         tick();
      end
   endtask

   task automatic do_ack();
      ack = 1; tick(); ack = 0;
   endtask

   task automatic pulse_ie();
      ie_set = 1; tick(); ie_set = 0;
   endtask

   task automatic write_mask(logic [2:0] m);
      mask_wdata = m; mask_wr = 1; tick(); mask_wr = 0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst = 0;
      run_cmp = 1;
      // R1: reset state
      chk("R1", "valid", int'(vector_valid), 0);
      chk("R1", "ie", int'(ie_state), 0);
      chk("R1", "src", int'(grant_src), 0);
      chk("R1", "addr", int'(vector_addr), 0);

      // R6: masks set after reset keep levels out even with enable
      cur_req = "R6";
      pulse_ie();
      chk("R7", "ie after set", int'(ie_state), 1);
      lvl65_in = 1; lvl55_in = 1; lvl75_in = 1;
      expect_idle("R6", 6);
      lvl65_in = 0; lvl55_in = 0; lvl75_in = 0;
      // R8: edge latched while masked, then cleared by command
      cur_req = "R8";
      rst75_cmd = 1; tick(); rst75_cmd = 0;
      write_mask(3'b000);
      expect_idle("R8", 4);

      // R7: acceptance clears enable; held level waits for ie_set
      cur_req = "R7";
      lvl65_in = 1;
      expect_vec("R3", 3, 'h34);
      chk("R7", "ie after accept", int'(ie_state), 0);
      do_ack();
      expect_idle("R7", 5);
      pulse_ie();
      expect_vec("R7", 3, 'h34);
      do_ack(); lvl65_in = 0; tick();

      // R10: ack while idle, and holding
      cur_req = "R10";
      do_ack();
      expect_idle("R10", 3);
      pulse_ie();
      lvl55_in = 1;
      expect_vec("R3", 4, 'h2C);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R10", "held vector", int'(vector_addr), 'h2C);
      end
      do_ack(); lvl55_in = 0; tick();

      // R6: per-line mask
      cur_req = "R6";
      write_mask(3'b001);
      pulse_ie();
      lvl55_in = 1;
      expect_idle("R6", 5);
      lvl65_in = 1;
      expect_vec("R6", 3, 'h34);
      do_ack(); lvl55_in = 0; lvl65_in = 0; tick();

      // R2: trap with every mask set and enable off
      cur_req = "R2";
      write_mask(3'b111);
      trap_in = 1;
      expect_vec("R2", 1, 'h24);
      chk("R2", "ie untouched", int'(ie_state), 0);
      do_ack();
      expect_idle("R9", 4);
      trap_in = 0; tick();

      // R9: short trap pulse is dropped
      cur_req = "R9";
      trap_in = 1; tick(); trap_in = 0;
      expect_idle("R9", 5);

      // R8: edge on 7.5 latched and served
      cur_req = "R8";
      write_mask(3'b000);
      pulse_ie();
      lvl75_in = 1; tick(); lvl75_in = 0;
      expect_vec("R8", 2, 'h3C);
      do_ack(); tick();
      lvl75_in = 1; tick(); lvl75_in = 0;
      rst75_cmd = 1; tick(); rst75_cmd = 0;
      pulse_ie();
      expect_idle("R8", 5);

      // R5: everything at once
      cur_req = "R5";
      trap_in = 1; lvl75_in = 1; tick();
      lvl65_in = 1; lvl55_in = 1;
      expect_vec("R5", 1, 'h24);
      do_ack();
      expect_vec("R5", 2, 'h3C);
      do_ack();
      pulse_ie();
      expect_vec("R5", 3, 'h34);
      do_ack(); lvl65_in = 0;
      pulse_ie();
      expect_vec("R5", 4, 'h2C);
      sw_req_idx = 5; sw_req_valid = 1;
      do_ack(); lvl55_in = 0;
      expect_vec("R5", 5, 'h28);
      ack = 1; tick(); ack = 0; sw_req_valid = 0;
      trap_in = 0; lvl75_in = 0; tick();

      // R4: every software restart number
      cur_req = "R4";
      for (int n = 0; n < 8; n++) begin
         sw_req_idx = 3'(n); sw_req_valid = 1;
         expect_vec("R4", 5, n * 8);
         ack = 1; tick(); ack = 0; sw_req_valid = 0; tick();
      end

      // random mix against the model
      cur_req = "R5";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 8 == 0) trap_in = ~trap_in;
         if ($urandom % 6 == 0) lvl75_in = ~lvl75_in;
         if ($urandom % 5 == 0) lvl65_in = ~lvl65_in;
         if ($urandom % 5 == 0) lvl55_in = ~lvl55_in;
         sw_req_valid = ($urandom % 4 == 0);
         sw_req_idx = 3'($urandom);
         mask_wr = ($urandom % 16 == 0);
         mask_wdata = 3'($urandom);
         ie_set = ($urandom % 4 == 0);
         rst75_cmd = ($urandom % 20 == 0);
         ack = ($urandom % 3 == 0);
         tick();
      end
      tick();
      finish_run();
   end

endmodule